// File: doc/BRIEF.md
# Barrel Thread Selector

This block sits at the front of a shared in-order pipeline. It holds several hardware thread contexts and chooses one of them to issue in each cycle. Each thread has a program counter, a flag that marks it as waiting for memory, and a flag that marks it as having an instruction in flight. Only threads that are neither waiting nor in flight can be chosen. A rotating pointer spreads the issue slots fairly among those threads.

The pipeline reports a writeback for each thread, and that writeback carries the address the thread continues from. The memory side reports when a thread starts waiting and when its data comes back. A thread can issue again only after two things have happened: its writeback has been taken, and a full pipeline depth of cycles has passed since it last issued. As a result a thread never has two instructions in the pipeline at once, and the pipeline needs no dependency checks or branch prediction. When no thread can issue, the block sends a bubble.

Top module: `barrel_thread_sel`

## Requirements
- R1: While `rst` is high, `issue_valid` is 0. The first issue after reset is released goes to thread 0 with its boot PC.
- R2: Among the eligible threads, the block issues the first one found by searching upward, with wrap-around, from the thread after the last one issued. With every thread eligible, the issued IDs run 0, 1, …, N-1, 0, ….
- R3: Two issue slots in consecutive cycles never carry the same thread ID.
- R4: After a thread issues, it is not issued again until both of these hold: a writeback for it has been registered, and at least PIPE_DEPTH cycles have passed since its previous issue. With a writeback that takes PIPE_DEPTH-1 cycles and N = PIPE_DEPTH, every thread issues exactly once every PIPE_DEPTH cycles.
- R5: A wait event registered for a thread keeps that thread from being selected until a return event for it is registered. If a wait and a return for the same thread arrive in the same cycle, the thread is left waiting.
- R6: In a cycle where no thread is eligible, `issue_valid` is 0 (a bubble).
- R7: A writeback replaces the thread's PC with `wb_next_pc`. The thread's next issue shows that value on `issue_pc`.
- R8: At reset, thread t holds PC = BOOT_PC + t·PC_STEP. Thread IDs are binary, clog2(N) bits wide. Outputs are registered, and an event registered at one clock edge affects the selection from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | A thread's instruction has completed writeback |
| wb_tid | input | clog2(N) | Thread of the completed instruction |
| wb_next_pc | input | PC_W | Address the thread continues from |
| mem_wait_valid | input | 1 | A thread starts waiting on memory |
| mem_wait_tid | input | clog2(N) | Thread that starts waiting |
| mem_ret_valid | input | 1 | Memory data returned for a thread |
| mem_ret_tid | input | clog2(N) | Thread whose data returned |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | clog2(N) | Thread that issues |
| issue_pc | output | PC_W | PC of the issuing thread |

## Verification
The first pattern runs all threads with a writeback that comes back just in time. This pattern must give a strict barrel rotation with no bubbles, so it separates correct rotation from a fixed-priority pick or a lost pointer. It also shows the boot PCs and the branch-target PC updates. A writeback slower than the pipeline depth must open bubbles while each thread still issues at a fixed rate; this separates the writeback gate from the depth counter. Memory blocking is tried on single threads, on a wait and a return that arrive in the same cycle, and on every thread at once. These cases tell the waiting group apart from the in-flight flag and make the block emit empty slots.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  // Slot visited at offset off in a circular search that starts at base.
  function automatic int unsigned rr_slot(int unsigned base, int unsigned off,
                                          int unsigned n);
    return (base + off) % n;
  endfunction
endpackage

// File: rtl/thr_status.sv
module thr_status #(
  parameter int N_THREADS  = 8,
  parameter int PIPE_DEPTH = 8,
  localparam int TID_W = $clog2(N_THREADS),
  localparam int AGE_W = $clog2(PIPE_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_fire,
  input  logic [TID_W-1:0]     issue_id,
  input  logic                 wb_valid,
  input  logic [TID_W-1:0]     wb_tid,
  input  logic                 wait_valid,
  input  logic [TID_W-1:0]     wait_tid,
  input  logic                 ret_valid,
  input  logic [TID_W-1:0]     ret_tid,
  output logic [N_THREADS-1:0] eligible
);
  localparam logic [AGE_W-1:0] AGE_LOAD = AGE_W'(PIPE_DEPTH - 1);

  for (genvar i = 0; i < N_THREADS; i++) begin : g_thr
    logic             busy_q;
    logic             blocked_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q <= 1'b0;
        age_q  <= '0;
      end else if (issue_fire && issue_id == TID_W'(i)) begin
        busy_q <= 1'b1;
        age_q  <= AGE_LOAD;
      end else begin
        if (wb_valid && wb_tid == TID_W'(i)) busy_q <= 1'b0;
        if (age_q != '0) age_q <= age_q - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                                      blocked_q <= 1'b0;
      else if (wait_valid && wait_tid == TID_W'(i)) blocked_q <= 1'b1;
      else if (ret_valid && ret_tid == TID_W'(i))   blocked_q <= 1'b0;
    end

    assign eligible[i] = !busy_q && !blocked_q && (age_q == '0);
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N_THREADS = 8,
  localparam int TID_W = $clog2(N_THREADS)
) (
  input  logic [N_THREADS-1:0] eligible,
  input  logic [TID_W-1:0]     start,
  output logic                 any,
  output logic [TID_W-1:0]     winner
);
  import barrel_pkg::*;

  always_comb begin
    any    = 1'b0;
    winner = '0;
    for (int k = 0; k < N_THREADS; k++) begin
      if (!any && eligible[rr_slot(int'(start), k, N_THREADS)]) begin
        any    = 1'b1;
        winner = TID_W'(rr_slot(int'(start), k, N_THREADS));
      end
    end
  end
endmodule

// File: rtl/pc_table.sv
module pc_table #(
  parameter int N_THREADS = 8,
  parameter int PC_W      = 32,
  parameter logic [PC_W-1:0] BOOT_PC = 'h1000,
  parameter logic [PC_W-1:0] PC_STEP = 'h100,
  localparam int TID_W = $clog2(N_THREADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TID_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [TID_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_data
);
  logic [PC_W-1:0] pc_mem [N_THREADS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_THREADS; k++)
        pc_mem[k] <= BOOT_PC + PC_W'(k) * PC_STEP;
    end else if (wr_en) begin
      pc_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = pc_mem[rd_idx];
endmodule

// File: rtl/barrel_thread_sel.sv
module barrel_thread_sel #(
  parameter int N_THREADS  = 8,
  parameter int PIPE_DEPTH = 8,
  parameter int PC_W       = 32,
  parameter logic [PC_W-1:0] BOOT_PC = 'h1000,
  parameter logic [PC_W-1:0] PC_STEP = 'h100,
  localparam int TID_W = $clog2(N_THREADS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_valid,
  input  logic [TID_W-1:0] wb_tid,
  input  logic [PC_W-1:0]  wb_next_pc,
  input  logic             mem_wait_valid,
  input  logic [TID_W-1:0] mem_wait_tid,
  input  logic             mem_ret_valid,
  input  logic [TID_W-1:0] mem_ret_tid,
  output logic             issue_valid,
  output logic [TID_W-1:0] issue_tid,
  output logic [PC_W-1:0]  issue_pc
);
  localparam logic [TID_W-1:0] LAST_ID = TID_W'(N_THREADS - 1);

  logic [N_THREADS-1:0] eligible;
  logic                 pick_any;
  logic [TID_W-1:0]     pick_id;
  logic [TID_W-1:0]     rr_ptr_q;
  logic [PC_W-1:0]      pick_pc;

  thr_status #(.N_THREADS(N_THREADS), .PIPE_DEPTH(PIPE_DEPTH)) status_i (
    .clk(clk), .rst(rst),
    .issue_fire(pick_any), .issue_id(pick_id),
    .wb_valid(wb_valid), .wb_tid(wb_tid),
    .wait_valid(mem_wait_valid), .wait_tid(mem_wait_tid),
    .ret_valid(mem_ret_valid), .ret_tid(mem_ret_tid),
    .eligible(eligible)
  );

  rr_pick #(.N_THREADS(N_THREADS)) pick_i (
    .eligible(eligible), .start(rr_ptr_q), .any(pick_any), .winner(pick_id)
  );

  pc_table #(.N_THREADS(N_THREADS), .PC_W(PC_W),
             .BOOT_PC(BOOT_PC), .PC_STEP(PC_STEP)) pcs_i (
    .clk(clk), .rst(rst),
    .wr_en(wb_valid), .wr_idx(wb_tid), .wr_data(wb_next_pc),
    .rd_idx(pick_id), .rd_data(pick_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr_q    <= '0;
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      issue_pc    <= '0;
    end else begin
      issue_valid <= pick_any;
      if (pick_any) begin
        rr_ptr_q  <= (pick_id == LAST_ID) ? '0 : pick_id + 1'b1;
        issue_tid <= pick_id;
        issue_pc  <= pick_pc;
      end
    end
  end
endmodule

// File: rtl/barrel_thread_sel_chk.sv
module barrel_thread_sel_chk #(
  parameter int N_THREADS = 8,
  localparam int TID_W = $clog2(N_THREADS)
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_valid,
  input logic [TID_W-1:0] wb_tid,
  input logic             mem_wait_valid,
  input logic [TID_W-1:0] mem_wait_tid,
  input logic             issue_valid,
  input logic [TID_W-1:0] issue_tid
);
  // Shadow of in-flight threads, built from the output issues and writeback inputs.
  logic [N_THREADS-1:0] flight_q, flight_d;

  always_comb begin
    flight_d = flight_q;
    if (wb_valid)    flight_d[wb_tid]    = 1'b0;
    if (issue_valid) flight_d[issue_tid] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flight_q <= '0;
    else     flight_q <= flight_d;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !issue_valid);

  // R3
  no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> !(issue_valid && issue_tid == $past(issue_tid)));

  // R4
  single_flight_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !flight_q[issue_tid]);

  // R5
  wait_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wait_valid |=> ##1 !(issue_valid && issue_tid == $past(mem_wait_tid, 2)));
endmodule

bind barrel_thread_sel barrel_thread_sel_chk #(.N_THREADS(N_THREADS)) chk_i (
  .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_tid(wb_tid),
  .mem_wait_valid(mem_wait_valid), .mem_wait_tid(mem_wait_tid),
  .issue_valid(issue_valid), .issue_tid(issue_tid)
);

// File: tb/barrel_thread_sel_tb_top.sv
`timescale 1ns/1ps
module barrel_thread_sel_tb_top;
  localparam int N = 8;
  localparam int D = 8;
  localparam int PW = 32;
  localparam int TW = $clog2(N);
  localparam logic [PW-1:0] BOOT = 32'h1000;
  localparam logic [PW-1:0] STEP = 32'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wb_valid = 1'b0;
  logic [TW-1:0] wb_tid = '0;
  logic [PW-1:0] wb_next_pc = '0;
  logic mem_wait_valid = 1'b0;
  logic [TW-1:0] mem_wait_tid = '0;
  logic mem_ret_valid = 1'b0;
  logic [TW-1:0] mem_ret_tid = '0;
  logic issue_valid;
  logic [TW-1:0] issue_tid;
  logic [PW-1:0] issue_pc;

  always #2.5 clk = ~clk;

  barrel_thread_sel #(.N_THREADS(N), .PIPE_DEPTH(D), .PC_W(PW),
                      .BOOT_PC(BOOT), .PC_STEP(STEP)) dut_i (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_tid(wb_tid),
    .wb_next_pc(wb_next_pc), .mem_wait_valid(mem_wait_valid),
    .mem_wait_tid(mem_wait_tid), .mem_ret_valid(mem_ret_valid),
    .mem_ret_tid(mem_ret_tid), .issue_valid(issue_valid),
    .issue_tid(issue_tid), .issue_pc(issue_pc)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state derived from the requirements
  bit mbusy[N], mblk[N], mnever[N];
  int mlast[N];
  logic [PW-1:0] mpc[N];
  int mptr, ecnt;
  // writeback responder
  bit plive[N];
  int prem[N];
  logic [PW-1:0] ppc[N];
  int lat = 7;
  // one-shot memory event knobs
  bit k_wv, k_rv;
  int k_wt, k_rt;
  // observations
  int iss_cnt[N];
  int bubbles, n3, nseq;
  bit prev_v;
  int prev_t;
  bit seen[N], ret_since[N];
  int last_act[N];
  logic [PW-1:0] first_pc[N];
  logic [PW-1:0] t3pc[4];
  int seq[16];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int t = 0; t < N; t++) iss_cnt[t] = 0;
    bubbles = 0;
  endtask

  task automatic step();
    bit ev;
    int ew, idx, t;
    logic [PW-1:0] epc;
    @(posedge clk); #1;
    ecnt++;
    ev = 0; ew = 0; epc = '0;
    for (int k = 0; k < N; k++) begin
      idx = (mptr + k) % N;
      if (!ev && !mbusy[idx] && !mblk[idx] && (mnever[idx] || ecnt - mlast[idx] >= D)) begin
        ev = 1; ew = idx; epc = mpc[idx];
      end
    end
    chk(issue_valid === ev, "R6", "issue_valid", issue_valid, ev);
    if (ev) begin
      chk(int'(issue_tid) == ew, "R2", "issue_tid", issue_tid, ew);
      chk(issue_pc == epc, "R7", "issue_pc", issue_pc, epc);
    end
    if (issue_valid) begin
      t = issue_tid;
      if (prev_v) chk(t != prev_t, "R3", "back-to-back tid", t, prev_t);
      if (seen[t]) chk(ret_since[t] && (ecnt - last_act[t] >= D), "R4",
                       "reissue gap", ecnt - last_act[t], D);
      if (!seen[t]) first_pc[t] = issue_pc;
      seen[t] = 1; last_act[t] = ecnt; ret_since[t] = 0; iss_cnt[t]++;
      if (t == 3 && n3 < 4) begin t3pc[n3] = issue_pc; n3++; end
      if (nseq < 16) begin seq[nseq] = t; nseq++; end
    end else bubbles++;
    prev_v = issue_valid; prev_t = issue_tid;
    // reference update with the inputs taken at this edge
    if (ev) begin mbusy[ew] = 1; mlast[ew] = ecnt; mnever[ew] = 0; mptr = (ew + 1) % N; end
    if (wb_valid) begin mbusy[wb_tid] = 0; mpc[wb_tid] = wb_next_pc; ret_since[wb_tid] = 1; end
    if (mem_ret_valid)  mblk[mem_ret_tid] = 0;
    if (mem_wait_valid) mblk[mem_wait_tid] = 1;
    // drive inputs for the next edge
    wb_valid = 0;
    for (int k = 0; k < N; k++) begin
      if (plive[k]) begin
        prem[k]--;
        if (prem[k] == 0) begin
          plive[k] = 0; wb_valid = 1; wb_tid = TW'(k); wb_next_pc = ppc[k];
        end
      end
    end
    if (ev) begin
      plive[ew] = 1; prem[ew] = lat - 1;
      ppc[ew] = epc + ((ew == 3) ? 32'h40 : 32'h4);
    end
    mem_wait_valid = k_wv; mem_wait_tid = TW'(k_wt);
    mem_ret_valid  = k_rv; mem_ret_tid  = TW'(k_rt);
    k_wv = 0; k_rv = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(posedge clk); #1;
      chk(issue_valid == 1'b0, "R1", "issue_valid in reset", issue_valid, 0);
    end
    for (int t = 0; t < N; t++) begin
      mbusy[t] = 0; mblk[t] = 0; mnever[t] = 1; mlast[t] = 0;
      mpc[t] = BOOT + PW'(t) * STEP; plive[t] = 0;
    end
    mptr = 0; ecnt = 0;
    rst = 0;
    step();
    chk(issue_valid && issue_tid == 0 && issue_pc == BOOT, "R1", "first issue pc",
        issue_pc, BOOT);
  endtask

  task automatic t_barrel();
    clear_counts();
    run(40);
    chk(bubbles == 0, "R2", "bubbles in full rotation", bubbles, 0);
    for (int i = 0; i < 10; i++)
      chk(seq[i] == i % N, "R2", "rotation order", seq[i], i % N);
    for (int t = 0; t < N; t++)
      chk(first_pc[t] == BOOT + PW'(t) * STEP, "R8", "boot pc", first_pc[t],
          BOOT + PW'(t) * STEP);
    chk(t3pc[1] == BOOT + 3 * STEP + 32'h40, "R7", "branch target pc", t3pc[1],
        BOOT + 3 * STEP + 32'h40);
    chk(t3pc[2] == BOOT + 3 * STEP + 32'h80, "R7", "second target pc", t3pc[2],
        BOOT + 3 * STEP + 32'h80);
  endtask

  task automatic t_mem_block();
    k_wv = 1; k_wt = 2; step();
    k_wv = 1; k_wt = 5; step();
    run(3);
    clear_counts();
    run(30);
    chk(iss_cnt[2] == 0, "R5", "blocked thread 2 issues", iss_cnt[2], 0);
    chk(iss_cnt[5] == 0, "R5", "blocked thread 5 issues", iss_cnt[5], 0);
    chk(iss_cnt[0] > 0, "R5", "unblocked thread 0 issues", iss_cnt[0], 1);
    k_rv = 1; k_rt = 2; step();
    k_rv = 1; k_rt = 5; step();
    clear_counts();
    run(20);
    chk(iss_cnt[2] > 0, "R5", "thread 2 after return", iss_cnt[2], 1);
    chk(iss_cnt[5] > 0, "R5", "thread 5 after return", iss_cnt[5], 1);
  endtask

  task automatic t_same_cycle();
    k_wv = 1; k_wt = 1; step();
    run(2);
    k_wv = 1; k_wt = 1; k_rv = 1; k_rt = 1; step();
    run(2);
    clear_counts();
    run(20);
    chk(iss_cnt[1] == 0, "R5", "wait wins over return", iss_cnt[1], 0);
    k_rv = 1; k_rt = 1; step();
    run(2);
  endtask

  task automatic t_all_blocked();
    int tot;
    for (int t = 0; t < N; t++) begin k_wv = 1; k_wt = t; step(); end
    run(2);
    clear_counts();
    run(20);
    tot = 0;
    for (int t = 0; t < N; t++) tot += iss_cnt[t];
    chk(tot == 0, "R6", "issues with all blocked", tot, 0);
    chk(bubbles == 20, "R6", "bubble count all blocked", bubbles, 20);
  endtask

  task automatic t_slow_wb();
    lat = 11;
    for (int t = 0; t < N; t++) begin k_rv = 1; k_rt = t; step(); end
    run(10);
    clear_counts();
    run(48);
    chk(bubbles == 16, "R6", "bubbles with slow writeback", bubbles, 16);
    for (int t = 0; t < N; t++)
      chk(iss_cnt[t] == 4, "R4", "issues per thread, slow writeback", iss_cnt[t], 4);
  endtask

  initial begin
    t_reset();
    t_barrel();
    t_mem_block();
    t_same_cycle();
    t_all_blocked();
    t_slow_wb();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule